// File: doc/BRIEF.md
# Chained DMA Descriptor Loader

This block is the front end of a single DMA channel. Given the byte address of a first command descriptor, it reads that descriptor from memory over a simple read-request port and writes each returned word into the channel's working registers. It then hands over to a transfer engine with a one-cycle `load_done_o` pulse and waits for `xfer_done_i`. If the loaded link word is nonzero, it repeats the sequence at the linked address. A link of zero ends the list and the channel goes idle.

A descriptor is eight 32-bit words. In order they are: link, source address, destination address, count, source step, destination step, control and status. Bit `SIMPLE_BIT` of the control register selects short descriptors. When the bit is set as a fetch begins, only the first four words are read. The step, control and status registers then keep the values they already held. When the bit is clear, all eight words are read, and this overwrites the status register. Each read request stays inside one `BOUND_WORDS`-word aligned block. A descriptor that would cross such a boundary is fetched with two requests, split at the boundary.

The controller has six states:
- ST_IDLE goes to ST_FETCH on an aligned start.
- ST_FETCH goes to ST_WAIT_DATA when the request is accepted.
- ST_WAIT_DATA goes back to ST_FETCH when a split remains. It goes to ST_LOAD after the last word.
- ST_LOAD goes to ST_TRANSFER.
- ST_TRANSFER goes to ST_CHECK_CHAIN on transfer done.
- ST_CHECK_CHAIN goes to ST_FETCH for a valid nonzero link. It goes to ST_IDLE for a zero link or a misaligned one.

Top module: `dma_desc_chain`

## Requirements
- R1: After reset the channel is idle. `busy_o`, `err_o`, `rd_req_o` and `load_done_o` are low, and all eight descriptor registers read zero.
- R2: Word k of a descriptor, read from byte address base+4k, loads the registers in this order: link (k=0), source, destination, count, source step, destination step, control, status (k=7). `load_done_o` pulses for exactly one cycle once the last word of the descriptor has arrived.
- R3: The simple bit is bit 0 of the control register. If it is 1 when a fetch begins, exactly 4 words are read. The source step, destination step, control and status registers keep their previous values.
- R4: If the simple bit is 0 when a fetch begins, exactly 8 words are read. All eight registers are loaded, including status.
- R5: After `xfer_done_i` is seen in the transfer state, a nonzero aligned link makes the next fetch start at that link address.
- R6: After the transfer of a descriptor whose link is zero, the channel returns to idle with `busy_o` low and issues no further read request.
- R7: Every read request covers at most the words up to the next 32-word aligned boundary. A descriptor that fits is read with one request. Otherwise the first request's length is the number of words to the boundary, and a second request covers the rest.
- R8: A start address or link with bits [1:0] nonzero sets `err_o` and leaves the channel idle without a read request. An accepted aligned start clears `err_o`.
- R9: `busy_o` is high in every state except idle. A `start_i` pulse while busy is ignored.
- R10: A read request holds `rd_req_o`, `rd_addr_o` and `rd_len_o` stable until `rd_ack_i`. Data words are taken only on cycles with `rd_valid_i` high.
- R11: The register values are persistent across runs. The first fetch of a new run uses the simple bit left by the previous run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| start_addr_i | input | 32 | Byte address of the first descriptor |
| rd_req_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Byte address of the first word of the burst |
| rd_len_o | output | 4 | Burst length in words |
| rd_ack_i | input | 1 | Request accepted |
| rd_valid_i | input | 1 | Returned data word valid |
| rd_data_i | input | 32 | Returned data word |
| load_done_o | output | 1 | One-cycle pulse: descriptor loaded |
| xfer_done_i | input | 1 | Transfer engine finished the descriptor |
| busy_o | output | 1 | Channel not idle |
| err_o | output | 1 | Misaligned descriptor address seen |
| chain_o | output | 32 | Link register |
| src_o | output | 32 | Source address register |
| dst_o | output | 32 | Destination address register |
| cnt_o | output | 32 | Count register |
| sinc_o | output | 32 | Source step register |
| dinc_o | output | 32 | Destination step register |
| ctrl_o | output | 32 | Control register |
| stat_o | output | 32 | Status register |

## Verification
The assertions check the following on every cycle:
- each request stays inside one aligned block;
- a pending request holds its address and length;
- the load pulse lasts one cycle and follows the final word;
- a short fetch never writes the upper four registers;
- an error always leaves the channel idle.

Only the bench scenarios can show the rest:
- the exact addresses walked through a five-descriptor list;
- which registers survive a short fetch;
- the split into two requests;
- the stop at a null link;
- the handling of a start pulse while busy, and of misaligned addresses.

The bench's reference model predicts all of these from memory contents alone.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT_DATA,
        ST_LOAD,
        ST_TRANSFER,
        ST_CHECK_CHAIN
    } chain_state_t;

    localparam int FULL_WORDS  = 8;
    localparam int SHORT_WORDS = 4;

    localparam int F_LINK = 0;
    localparam int F_SRC  = 1;
    localparam int F_DST  = 2;
    localparam int F_CNT  = 3;
    localparam int F_SINC = 4;
    localparam int F_DINC = 5;
    localparam int F_CTRL = 6;
    localparam int F_STAT = 7;

endpackage

// File: rtl/dma_desc_burst.sv
// Burst length planner: clips the remaining word count to the words left
// before the next aligned block boundary.
module dma_desc_burst #(
    parameter int BOUND_WORDS = 32,
    parameter int LEN_W       = 4,
    localparam int OFF_W      = $clog2(BOUND_WORDS)
) (
    input  logic [OFF_W-1:0] word_off_i,
    input  logic [LEN_W-1:0] remain_i,
    output logic [LEN_W-1:0] len_o
);
    localparam int RW = (OFF_W + 1 > LEN_W) ? OFF_W + 1 : LEN_W;

    logic [RW-1:0] room;
    logic [RW-1:0] rem_ext;

    always_comb begin
        room    = RW'(BOUND_WORDS) - RW'(word_off_i);
        rem_ext = RW'(remain_i);
        len_o   = (room < rem_ext) ? LEN_W'(room) : remain_i;
    end
endmodule

// File: rtl/dma_desc_regs.sv
// Descriptor register bank: one word written per returned data beat.
module dma_desc_regs #(
    parameter int DW    = 32,
    parameter int NREG  = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [IDXW-1:0]           wr_idx_i,
    input  logic [DW-1:0]             wr_data_i,
    output logic [NREG-1:0][DW-1:0]   regs_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_o[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == IDXW'(g))) begin
                regs_o[g] <= wr_data_i;
            end
        end
    end
endmodule

// File: rtl/dma_desc_chain.sv
module dma_desc_chain
    import dma_desc_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int BOUND_WORDS = 32,
    parameter int SIMPLE_BIT  = 0,
    parameter int LEN_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    start_addr_i,
    output logic             rd_req_o,
    output logic [AW-1:0]    rd_addr_o,
    output logic [LEN_W-1:0] rd_len_o,
    input  logic             rd_ack_i,
    input  logic             rd_valid_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic             load_done_o,
    input  logic             xfer_done_i,
    output logic             busy_o,
    output logic             err_o,
    output logic [DW-1:0]    chain_o,
    output logic [DW-1:0]    src_o,
    output logic [DW-1:0]    dst_o,
    output logic [DW-1:0]    cnt_o,
    output logic [DW-1:0]    sinc_o,
    output logic [DW-1:0]    dinc_o,
    output logic [DW-1:0]    ctrl_o,
    output logic [DW-1:0]    stat_o
);
    localparam int OFF_W = $clog2(BOUND_WORDS);
    localparam int IDXW  = $clog2(FULL_WORDS);

    chain_state_t state_q, state_d;

    logic [AW-1:0]              base_q;
    logic [LEN_W-1:0]           idx_q;
    logic [LEN_W-1:0]           total_q;
    logic [LEN_W-1:0]           beats_q;
    logic                       err_q;
    logic [LEN_W-1:0]           remain;
    logic [LEN_W-1:0]           burst_len;
    logic                       wr_en;
    logic [FULL_WORDS-1:0][DW-1:0] regs;
    logic                       start_ok;
    logic                       link_zero;
    logic                       link_ok;
    logic [LEN_W-1:0]           mode_words;

    assign start_ok   = (start_addr_i[1:0] == 2'b00);
    assign link_zero  = (regs[F_LINK] == '0);
    assign link_ok    = (regs[F_LINK][1:0] == 2'b00);
    assign mode_words = regs[F_CTRL][SIMPLE_BIT] ? LEN_W'(SHORT_WORDS)
                                                 : LEN_W'(FULL_WORDS);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start_i && start_ok) state_d = ST_FETCH;
            ST_FETCH:       if (rd_ack_i) state_d = ST_WAIT_DATA;
            ST_WAIT_DATA:   if (rd_valid_i && beats_q == LEN_W'(1))
                                state_d = (idx_q + LEN_W'(1) == total_q) ? ST_LOAD : ST_FETCH;
            ST_LOAD:        state_d = ST_TRANSFER;
            ST_TRANSFER:    if (xfer_done_i) state_d = ST_CHECK_CHAIN;
            ST_CHECK_CHAIN: state_d = (!link_zero && link_ok) ? ST_FETCH : ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        rd_req_o    = (state_q == ST_FETCH);
        load_done_o = (state_q == ST_LOAD);
        wr_en       = (state_q == ST_WAIT_DATA) && rd_valid_i;
        rd_addr_o   = base_q + {{(AW-LEN_W-2){1'b0}}, idx_q, 2'b00};
        remain      = total_q - idx_q;
        rd_len_o    = burst_len;
        err_o       = err_q;
    end

    // datapath counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            idx_q   <= '0;
            total_q <= '0;
            beats_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    if (start_ok) begin
                        base_q  <= start_addr_i;
                        idx_q   <= '0;
                        total_q <= mode_words;
                        err_q   <= 1'b0;
                    end else begin
                        err_q   <= 1'b1;
                    end
                end
                ST_FETCH: if (rd_ack_i) beats_q <= burst_len;
                ST_WAIT_DATA: if (rd_valid_i) begin
                    idx_q   <= idx_q + LEN_W'(1);
                    beats_q <= beats_q - LEN_W'(1);
                end
                ST_CHECK_CHAIN: begin
                    if (!link_zero && link_ok) begin
                        base_q  <= regs[F_LINK][AW-1:0];
                        idx_q   <= '0;
                        total_q <= mode_words;
                    end else if (!link_zero) begin
                        err_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    dma_desc_burst #(
        .BOUND_WORDS(BOUND_WORDS),
        .LEN_W      (LEN_W)
    ) u_burst (
        .word_off_i (rd_addr_o[OFF_W+1:2]),
        .remain_i   (remain),
        .len_o      (burst_len)
    );

    dma_desc_regs #(
        .DW   (DW),
        .NREG (FULL_WORDS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (idx_q[IDXW-1:0]),
        .wr_data_i (rd_data_i),
        .regs_o    (regs)
    );

    assign chain_o = regs[F_LINK];
    assign src_o   = regs[F_SRC];
    assign dst_o   = regs[F_DST];
    assign cnt_o   = regs[F_CNT];
    assign sinc_o  = regs[F_SINC];
    assign dinc_o  = regs[F_DINC];
    assign ctrl_o  = regs[F_CTRL];
    assign stat_o  = regs[F_STAT];

    // R7: a request never runs past an aligned block boundary and is never empty
    a_r7_burst_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_len_o != '0) &&
                     (int'(rd_addr_o[OFF_W+1:2]) + int'(rd_len_o) <= BOUND_WORDS));

    // R10: a pending request holds address and length
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_len_o));

    // R2: load pulse is one cycle and comes only after every word arrived
    a_r2_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |=> !load_done_o);
    a_r2_load_complete: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |-> (idx_q == total_q) && (beats_q == '0));

    // R3: a short fetch never writes the upper four registers
    a_r3_short_no_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && total_q == LEN_W'(SHORT_WORDS)) |=>
            $stable(sinc_o) && $stable(dinc_o) && $stable(ctrl_o) && $stable(stat_o));

    // R8: an error leaves the channel idle
    a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o);
endmodule

// File: tb/dma_desc_chain_bench.sv
`timescale 1ns/1ps
module dma_desc_chain_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic [3:0]  rd_len_o;
    logic        rd_ack_i = 1'b0;
    logic        rd_valid_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic        load_done_o;
    logic        xfer_done_i = 1'b0;
    logic        busy_o, err_o;
    logic [31:0] chain_o, src_o, dst_o, cnt_o, sinc_o, dinc_o, ctrl_o, stat_o;

    always #2 clk = ~clk;

    dma_desc_chain u_dma_desc_chain (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_len_o(rd_len_o),
        .rd_ack_i(rd_ack_i), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .load_done_o(load_done_o), .xfer_done_i(xfer_done_i),
        .busy_o(busy_o), .err_o(err_o),
        .chain_o(chain_o), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o),
        .sinc_o(sinc_o), .dinc_o(dinc_o), .ctrl_o(ctrl_o), .stat_o(stat_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    logic [31:0]  mem [logic [31:0]];
    logic [31:0]  mreg [8];
    logic [31:0]  q_addr [$];
    int           q_len  [$];
    logic [255:0] q_snap [$];
    bit           q_short [$];
    int           exp_words;
    bit           exp_err;

    int          beats_left = 0;
    logic [31:0] raddr = '0;
    bit          toggle = 0;
    bit          seen = 0;
    logic [31:0] seen_addr = '0;
    logic [3:0]  seen_len = '0;
    int          xd = 0;
    int          words_seen = 0;
    int          reqs_seen = 0;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rdmem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [255:0] snap_now();
        return {stat_o, ctrl_o, dinc_o, sinc_o, cnt_o, dst_o, src_o, chain_o};
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, w1, w2, w3,
                            w4, w5, w6, w7);
        mem[a]      = w0; mem[a + 4]  = w1; mem[a + 8]  = w2; mem[a + 12] = w3;
        mem[a + 16] = w4; mem[a + 20] = w5; mem[a + 24] = w6; mem[a + 28] = w7;
    endtask

    // behavioural reference: walks the list in memory and predicts requests and loads
    task automatic plan_run(input logic [31:0] start);
        logic [31:0] a;
        exp_words = 0;
        a = start;
        if (a[1:0] != 2'b00) begin
            exp_err = 1;
            return;
        end
        exp_err = 0;
        forever begin
            int n, off, first;
            bit sh;
            sh    = mreg[6][0];
            n     = sh ? 4 : 8;
            off   = int'((a >> 2) % 32);
            first = (32 - off < n) ? 32 - off : n;
            q_addr.push_back(a);
            q_len.push_back(first);
            if (first < n) begin
                q_addr.push_back(a + 32'(4 * first));
                q_len.push_back(n - first);
            end
            for (int k = 0; k < n; k++) mreg[k] = rdmem(a + 32'(4 * k));
            exp_words += n;
            q_snap.push_back({mreg[7], mreg[6], mreg[5], mreg[4],
                              mreg[3], mreg[2], mreg[1], mreg[0]});
            q_short.push_back(sh);
            if (mreg[0] == 32'h0) break;
            if (mreg[0][1:0] != 2'b00) begin
                exp_err = 1;
                break;
            end
            a = mreg[0];
        end
    endtask

    // memory and transfer-engine responder
    always @(negedge clk) begin
        rd_ack_i    = 1'b0;
        rd_valid_i  = 1'b0;
        xfer_done_i = 1'b0;
        if (!rst_n) begin
            beats_left = 0;
            seen = 0;
            xd = 0;
        end else begin
            toggle = ~toggle;
            if (beats_left > 0) begin
                if (toggle) begin
                    rd_valid_i = 1'b1;
                    rd_data_i  = rdmem(raddr);
                    raddr      = raddr + 4;
                    beats_left--;
                    words_seen++;
                end
            end else if (rd_req_o) begin
                if (!seen) begin
                    seen      = 1;
                    seen_addr = rd_addr_o;
                    seen_len  = rd_len_o;
                end else begin
                    seen = 0;
                    chk(rd_addr_o == seen_addr && rd_len_o == seen_len,
                        "R10 request held stable", {rd_addr_o, rd_len_o}, {seen_addr, seen_len});
                    if (q_addr.size() == 0) begin
                        chk(0, "R6 unexpected read request", rd_addr_o, 0);
                    end else begin
                        logic [31:0] ea;
                        int el;
                        ea = q_addr.pop_front();
                        el = q_len.pop_front();
                        chk(rd_addr_o == ea, "R5 request address", rd_addr_o, ea);
                        chk(int'(rd_len_o) == el, "R7 request length", rd_len_o, el);
                    end
                    rd_ack_i   = 1'b1;
                    raddr      = rd_addr_o;
                    beats_left = int'(rd_len_o);
                    reqs_seen++;
                end
            end
            if (load_done_o) begin
                chk(busy_o == 1'b1, "R9 busy during load", busy_o, 1);
                if (q_snap.size() == 0) begin
                    chk(0, "R2 unexpected load", snap_now(), 0);
                end else begin
                    logic [255:0] es;
                    bit sh;
                    es = q_snap.pop_front();
                    sh = q_short.pop_front();
                    chk(snap_now() == es, sh ? "R3 short descriptor registers"
                                             : "R4 full descriptor registers (R2 order)",
                        snap_now(), es);
                end
                xd = 3;
            end else if (xd > 0) begin
                xd--;
                if (xd == 0) xfer_done_i = 1'b1;
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) mreg[k] = 32'h0;
        @(negedge clk);
    endtask

    task automatic run_chain(input logic [31:0] start, input bit poke_busy);
        int w0, r0;
        plan_run(start);
        words_seen = 0;
        @(negedge clk);
        start_addr_i = start;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke_busy) begin
            repeat (20) @(negedge clk);
            chk(busy_o == 1'b1, "R9 busy mid-chain", busy_o, 1);
            start_addr_i = 32'h0000_0900;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        r0 = reqs_seen;
        w0 = words_seen;
        repeat (6) @(negedge clk);
        chk(reqs_seen == r0, "R6 no request after end", reqs_seen, r0);
        chk(q_addr.size() == 0, "R5 all predicted requests seen", q_addr.size(), 0);
        chk(q_snap.size() == 0, "R2 all predicted loads seen", q_snap.size(), 0);
        chk(w0 == exp_words, "R3 R4 words fetched", w0, exp_words);
        chk(busy_o == 1'b0, "R6 idle at end", busy_o, 0);
        chk(err_o == exp_err, "R8 error flag", err_o, exp_err);
        q_addr.delete(); q_len.delete(); q_snap.delete(); q_short.delete();
    endtask

    initial begin
        // five-descriptor list: A,B full; B sets simple bit so C,D,E are short
        put_desc(32'h100, 32'h200, 32'hA001, 32'hA002, 32'hA003, 32'h4, 32'h8, 32'h20, 32'h11);
        put_desc(32'h200, 32'h3F0, 32'hB001, 32'hB002, 32'hB003, 32'hC, 32'h10, 32'h21, 32'h55);
        put_desc(32'h3F0, 32'h4F8, 32'hC001, 32'hC002, 32'hC003, 32'hDEAD, 32'hDEAD, 32'hDEAD, 32'hDEAD);
        put_desc(32'h4F8, 32'h600, 32'hD001, 32'hD002, 32'hD003, 32'hBEEF, 32'hBEEF, 32'hBEEF, 32'hBEEF);
        put_desc(32'h600, 32'h0,   32'hE001, 32'hE002, 32'hE003, 32'hF00D, 32'hF00D, 32'hF00D, 32'hF00D);
        // split full descriptor with misaligned link
        put_desc(32'h7F0, 32'h803, 32'hF001, 32'hF002, 32'hF003, 32'h1, 32'h2, 32'h0, 32'h77);
        // full descriptor that sets simple bit, then a short one
        put_desc(32'hA00, 32'h0, 32'h1001, 32'h1002, 32'h1003, 32'h5, 32'h6, 32'h1, 32'hA5);
        put_desc(32'hB00, 32'h0, 32'h2001, 32'h2002, 32'h2003, 32'h99, 32'h99, 32'h99, 32'h99);

        do_reset();
        chk(busy_o == 0 && err_o == 0, "R1 reset idle/err", {busy_o, err_o}, 0);
        chk(rd_req_o == 0 && load_done_o == 0, "R1 reset req/load", {rd_req_o, load_done_o}, 0);
        chk(snap_now() == '0, "R1 reset registers", snap_now(), 0);

        run_chain(32'h100, 1);      // R5 R6 R3 R4 R7 R9 R10
        do_reset();
        run_chain(32'h7F0, 0);      // R7 split, R8 misaligned link
        run_chain(32'hA00, 0);      // R8 clear on start, R4
        run_chain(32'hB00, 0);      // R11 simple bit persists: short first fetch
        chk(stat_o == 32'hA5 && ctrl_o == 32'h1, "R11 upper registers kept",
            {stat_o, ctrl_o}, {32'hA5, 32'h1});
        run_chain(32'h902, 0);      // R8 misaligned start, no request

        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done_flag) begin
            done_flag = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule